// File: doc/BRIEF.md
# Dual Interval Timer Unit

This block holds two interval timers, A and B, each a 16-bit up-counter. Both are paced by one external timer clock. That clock is asynchronous, so it is resynchronised into the system clock domain. Its falling edges become count ticks only once they are aligned to the processor's machine-cycle strobe. Timer A advances once per tick. Timer B passes its ticks through a fixed divide-by-ten prescaler, so it advances at one tenth of timer A's rate.

Each timer has its own load, start and halt command pulses. These stand in for the processor's internal I/O commands, and a shared data word supplies the load value. The current counts appear on output ports. Each timer has its own overflow output, which pulses for one cycle when the counter wraps to zero. An active-low suspend input freezes everything: counts, run state and prescaler phase. A second mechanism stops counting while a breakpoint hold is in force, but only if the enable for that option is set. All inputs except the timer clock are synchronous to `clk`. No data stream passes through the block, so every pin is a plain control or status line and there is no back-pressure.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both counters read 0, both overflow outputs are low, and both timers are halted. No tick changes a count until a start command is given.
- R2: The timer clock is resynchronised through two flops and its falling edge is detected; this is seen three `clk` edges after the input falls. A strobe falling edge is a cycle where `cyc_strobe` is low and was high in the previous cycle. A tick is produced on the second strobe falling edge after the timer clock edge was seen. Several timer clock edges seen before the same strobe falling edge merge into one tick.
- R3: A running timer A increments by exactly one on each tick, and the new value is visible on the clock edge that consumes the tick.
- R4: A running timer B increments once for every ten ticks. Its prescaler advances only on ticks that arrive while timer B runs and counting is not stopped.
- R5: A counter wraps from 0xFFFF to 0x0000. In the same cycle that the counter shows 0x0000, the timer's own overflow output is high for exactly one cycle.
- R6: A load command writes `ld_val` into that timer's counter on the next clock edge and clears its prescaler phase. A load takes precedence over a tick in the same cycle.
- R7: A start command sets the timer running and a halt command stops it; if both are given in the same cycle, halt wins. A halted timer keeps its count.
- R8: While `susp_n` is low, both counts, both run states and timer B's prescaler phase hold their values, and load, start and halt commands have no effect. When `susp_n` returns high, counting resumes from the held values.
- R9: While `bkpt_hold` and `halt_on_bkpt` are both high, both timers stop counting and their prescaler phase holds, but commands still act. With `halt_on_bkpt` low, `bkpt_hold` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tclk_in | input | 1 | External timer clock, asynchronous |
| cyc_strobe | input | 1 | Machine-cycle strobe, synchronous to clk |
| susp_n | input | 1 | Active-low suspend of both timers |
| bkpt_hold | input | 1 | Breakpoint hold in force |
| halt_on_bkpt | input | 1 | Enables stopping the timers on breakpoint hold |
| ld_val | input | 16 | Value written by a load command |
| ld_a | input | 1 | Load timer A |
| start_a | input | 1 | Start timer A |
| halt_a | input | 1 | Halt timer A |
| ld_b | input | 1 | Load timer B |
| start_b | input | 1 | Start timer B |
| halt_b | input | 1 | Halt timer B |
| cnt_a | output | 16 | Timer A count |
| cnt_b | output | 16 | Timer B count |
| ovf_a | output | 1 | Timer A wrap pulse |
| ovf_b | output | 1 | Timer B wrap pulse |

## Verification
A command acts on the first `clk` edge after it is driven, so a load, start or halt shows up one cycle later. A falling timer clock edge needs three edges to be seen. It then waits for two strobe falls, and the count and overflow change on the edge of the second fall. The bench has a behavioural model that applies these delays to the same inputs. It compares every output against the model at each falling clock edge, away from the edge where the design updates. Explicit checks also cover the reset values, the value that follows a load, and the number of overflow pulses in the wrap phase.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int unsigned DIT_NUM_TMR = 2;

  typedef struct packed {
    logic load;
    logic start;
    logic halt;
  } tmr_cmd_t;
endpackage

// File: rtl/dit_tclk_sync.sv
module dit_tclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk_async,
  output logic tclk_fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tclk_async};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign tclk_fall = last_q & ~sync_q[STAGES-1];

  assert_fall_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tclk_fall |=> !tclk_fall);
endmodule

// File: rtl/dit_tick_qual.sv
module dit_tick_qual #(
  parameter int unsigned QUAL_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic tclk_fall,
  output logic tick
);
  localparam int unsigned SW = QUAL_DEPTH - 1;

  logic          strobe_q;
  logic          seen_q;
  logic [SW-1:0] stage_q;
  logic          sfall;
  logic          capture;

  assign sfall   = strobe_q & ~strobe;
  assign capture = seen_q | tclk_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      strobe_q <= strobe;
      seen_q   <= sfall ? 1'b0 : capture;
    end
  end

  generate
    if (QUAL_DEPTH == 2) begin : g_one_stage
      always_ff @(posedge clk) begin
        if (!rst_n)     stage_q <= '0;
        else if (sfall) stage_q <= capture;
      end
    end else begin : g_multi_stage
      always_ff @(posedge clk) begin
        if (!rst_n)     stage_q <= '0;
        else if (sfall) stage_q <= {stage_q[SW-2:0], capture};
      end
    end
  endgenerate

  assign tick = sfall & stage_q[SW-1];

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  assert_tick_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $fell(strobe));
endmodule

// File: rtl/dit_timer_chan.sv
module dit_timer_chan
  import dit_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             stall,
  input  logic             tick,
  input  tmr_cmd_t         cmd,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             ovf_q;
  logic             adv;
  logic             step;

  assign adv = run_q & tick & ~stall;

  generate
    if (DIV > 1) begin : g_presc
      logic [PW-1:0] presc_q;
      logic          at_last;
      assign at_last = (presc_q == PW'(DIV - 1));
      assign step    = adv & at_last;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          presc_q <= '0;
        end else if (!freeze) begin
          if (cmd.load)   presc_q <= '0;
          else if (adv)   presc_q <= at_last ? '0 : presc_q + PW'(1);
        end
      end
      assert_presc_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(presc_q));
      assert_presc_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !cmd.load) |=> $stable(presc_q));
    end else begin : g_direct
      assign step = adv;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (!freeze) begin
        if (cmd.halt)       run_q <= 1'b0;
        else if (cmd.start) run_q <= 1'b1;
        if (cmd.load) begin
          cnt_q <= ld_val;
        end else if (step) begin
          cnt_q <= cnt_q + CNT_W'(1);
          ovf_q <= &cnt_q;
        end
      end
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

  assert_freeze_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(cnt_q) && $stable(run_q)));
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !cmd.load) |=> (CNT_W'(cnt_q - $past(cnt_q)) <= CNT_W'(1)));
  assert_ovf_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0));
  assert_ovf_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q);
  assert_load_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.load && !freeze) |=> (cnt_q == $past(ld_val)));
  assert_halt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.halt && !freeze) |=> !run_q);
  assert_halted_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cmd.load) |=> $stable(cnt_q));
  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !cmd.load) |=> $stable(cnt_q));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned A_DIV      = 1,
  parameter int unsigned B_DIV      = 10,
  parameter int unsigned SYNC_STG   = 2,
  parameter int unsigned QUAL_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tclk_in,
  input  logic             cyc_strobe,
  input  logic             susp_n,
  input  logic             bkpt_hold,
  input  logic             halt_on_bkpt,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             ld_a,
  input  logic             start_a,
  input  logic             halt_a,
  input  logic             ld_b,
  input  logic             start_b,
  input  logic             halt_b,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b,
  output logic             ovf_a,
  output logic             ovf_b
);
  logic             tclk_fall;
  logic             tick;
  logic             freeze;
  logic             stall;
  tmr_cmd_t         cmd   [DIT_NUM_TMR];
  logic [CNT_W-1:0] cnt_v [DIT_NUM_TMR];
  logic             ovf_v [DIT_NUM_TMR];

  assign freeze = ~susp_n;
  assign stall  = bkpt_hold & halt_on_bkpt;
  assign cmd[0] = {ld_a, start_a, halt_a};
  assign cmd[1] = {ld_b, start_b, halt_b};

  dit_tclk_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .tclk_async (tclk_in),
    .tclk_fall  (tclk_fall)
  );

  dit_tick_qual #(.QUAL_DEPTH(QUAL_DEPTH)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (cyc_strobe),
    .tclk_fall (tclk_fall),
    .tick      (tick)
  );

  generate
    for (genvar gi = 0; gi < DIT_NUM_TMR; gi++) begin : g_tmr
      dit_timer_chan #(
        .CNT_W (CNT_W),
        .DIV   ((gi == 0) ? A_DIV : B_DIV)
      ) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (freeze),
        .stall  (stall),
        .tick   (tick),
        .cmd    (cmd[gi]),
        .ld_val (ld_val),
        .cnt    (cnt_v[gi]),
        .ovf    (ovf_v[gi])
      );
    end
  endgenerate

  assign cnt_a = cnt_v[0];
  assign cnt_b = cnt_v[1];
  assign ovf_a = ovf_v[0];
  assign ovf_b = ovf_v[1];

  assert_no_pulse_when_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> (!ovf_a && !ovf_b));
endmodule

// File: tb/test_dual_interval_timer.sv
`timescale 1ns/1ps
module test_dual_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tclk_in = 1'b0;
  logic        cyc_strobe = 1'b0;
  logic        susp_n = 1'b1;
  logic        bkpt_hold = 1'b0;
  logic        halt_on_bkpt = 1'b0;
  logic [15:0] ld_val = '0;
  logic        ld_a = 0, start_a = 0, halt_a = 0;
  logic        ld_b = 0, start_b = 0, halt_b = 0;
  logic [15:0] cnt_a, cnt_b;
  logic        ovf_a, ovf_b;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";
  int    tper = 12;
  int    tph = 0;
  int    sph = 0;
  int    seen_ovf_a = 0;
  int    seen_ovf_b = 0;

  always #2.5 clk = ~clk;

  dual_interval_timer i_dual_interval_timer (
    .clk(clk), .rst_n(rst_n), .tclk_in(tclk_in), .cyc_strobe(cyc_strobe),
    .susp_n(susp_n), .bkpt_hold(bkpt_hold), .halt_on_bkpt(halt_on_bkpt),
    .ld_val(ld_val), .ld_a(ld_a), .start_a(start_a), .halt_a(halt_a),
    .ld_b(ld_b), .start_b(start_b), .halt_b(halt_b),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .ovf_a(ovf_a), .ovf_b(ovf_b)
  );

  // background timer clock and strobe, driven away from the active edge
  always @(negedge clk) begin
    tph = (tph + 1) % tper;
    tclk_in <= (tph < tper / 2);
    sph = (sph + 1) % 4;
    cyc_strobe <= (sph < 2);
  end

  // behavioural reference model
  int m_h0, m_h1, m_h2, m_strb, m_seen, m_pend;
  int m_cnt_a, m_cnt_b, m_run_a, m_run_b, m_pre_b, m_ovf_a, m_ovf_b;
  int fall_now, sfall, tk, stop_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h0 = 0; m_h1 = 0; m_h2 = 0; m_strb = 0; m_seen = 0; m_pend = 0;
      m_cnt_a = 0; m_cnt_b = 0; m_run_a = 0; m_run_b = 0; m_pre_b = 0;
      m_ovf_a = 0; m_ovf_b = 0;
    end else begin
      fall_now = (m_h2 == 1 && m_h1 == 0);
      m_h2 = m_h1; m_h1 = m_h0; m_h0 = tclk_in;
      sfall = (m_strb == 1 && cyc_strobe == 0);
      m_strb = cyc_strobe;
      tk = sfall && m_pend;
      if (sfall) begin m_pend = m_seen || fall_now; m_seen = 0; end
      else m_seen = m_seen || fall_now;
      m_ovf_a = 0; m_ovf_b = 0;
      stop_cnt = halt_on_bkpt && bkpt_hold;
      if (susp_n) begin
        if (ld_a) m_cnt_a = ld_val;
        else if (m_run_a && tk && !stop_cnt) begin
          m_ovf_a = (m_cnt_a == 65535);
          m_cnt_a = (m_cnt_a + 1) % 65536;
        end
        if (ld_b) begin m_cnt_b = ld_val; m_pre_b = 0; end
        else if (m_run_b && tk && !stop_cnt) begin
          m_pre_b = m_pre_b + 1;
          if (m_pre_b == 10) begin
            m_pre_b = 0;
            m_ovf_b = (m_cnt_b == 65535);
            m_cnt_b = (m_cnt_b + 1) % 65536;
          end
        end
        if (halt_a) m_run_a = 0; else if (start_a) m_run_a = 1;
        if (halt_b) m_run_b = 0; else if (start_b) m_run_b = 1;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      chk(cur_req, "cnt_a", int'(cnt_a), m_cnt_a);
      chk(cur_req, "cnt_b", int'(cnt_b), m_cnt_b);
      chk(cur_req, "ovf_a", int'(ovf_a), m_ovf_a);
      chk(cur_req, "ovf_b", int'(ovf_b), m_ovf_b);
      if (ovf_a) seen_ovf_a++;
      if (ovf_b) seen_ovf_b++;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, no counting before start
    chk("R1", "cnt_a after reset", int'(cnt_a), 0);
    chk("R1", "cnt_b after reset", int'(cnt_b), 0);
    chk("R1", "ovf after reset", int'({ovf_a, ovf_b}), 0);
    cmp_on = 1;
    cur_req = "R1";
    idle(60);
    chk("R1", "cnt_a still halted", int'(cnt_a), 0);

    // R2, R3, R4: start both and run at the base timer clock rate
    cur_req = "R3";
    start_a = 1; start_b = 1; @(negedge clk); start_a = 0; start_b = 0;
    idle(400);
    cur_req = "R2";
    tper = 3;
    idle(300);
    tper = 12;
    cur_req = "R4";
    idle(300);

    // R6 and R5: load near wrap point and observe one pulse each
    cur_req = "R6";
    ld_val = 16'hFFFC; ld_a = 1; @(negedge clk); ld_a = 0;
    chk("R6", "cnt_a after load", int'(cnt_a), 16'hFFFC);
    ld_val = 16'hFFFF; ld_b = 1; @(negedge clk); ld_b = 0;
    chk("R6", "cnt_b after load", int'(cnt_b), 16'hFFFF);
    cur_req = "R5";
    seen_ovf_a = 0; seen_ovf_b = 0;
    idle(220);
    chk("R5", "ovf_a pulses", seen_ovf_a, 1);
    chk("R5", "ovf_b pulses", seen_ovf_b, 1);

    // R7: start and halt together, halt wins
    cur_req = "R7";
    start_a = 1; halt_a = 1; start_b = 1; halt_b = 1;
    @(negedge clk);
    start_a = 0; halt_a = 0; start_b = 0; halt_b = 0;
    idle(150);
    start_a = 1; start_b = 1; @(negedge clk); start_a = 0; start_b = 0;
    idle(100);

    // R8: suspend freezes state and blocks commands
    cur_req = "R8";
    susp_n = 0;
    idle(30);
    ld_val = 16'h1234; ld_a = 1; halt_b = 1; @(negedge clk); ld_a = 0; halt_b = 0;
    idle(120);
    susp_n = 1;
    idle(200);

    // R9: breakpoint hold with and without the enable
    cur_req = "R9";
    halt_on_bkpt = 1; bkpt_hold = 1;
    idle(150);
    ld_val = 16'h0042; ld_a = 1; @(negedge clk); ld_a = 0;
    chk("R9", "load during hold", int'(cnt_a), 16'h0042);
    idle(100);
    halt_on_bkpt = 0;
    idle(200);
    bkpt_hold = 0;
    idle(50);

    finish_run();
  end
endmodule